// File: doc/BRIEF.md
# Banked CPU-Interface Control Register

This block holds one 32-bit control word and one 8-bit priority mask for each processor attached to an interrupt controller. It also gates the interrupt line and pending-ID bus that the controller sends to each processor. Accesses arrive on a small register port that carries an address, a write strobe, write data, a processor index and a secure attribute. Read data appears one clock after the address.

Two static parameters select the register revision (1 or 2) and whether a security extension is present. The storage is a single copy per processor in every configuration. When the extension is present, a non-secure access does not see that copy directly. It sees an alias built by shifting two secure-side bits down one position. A non-secure write can change only those aliased bits.

Top module: `cpuif_ctrl_bank`

## Requirements
- R1: After reset, every control word and priority mask is zero, `rd_data` is zero, every `irq_out` bit is low and every pending-ID slice reads 1023.
- R2: A write to offset 0x000 that is secure, or any such write when the extension is absent, stores the write data ANDed with a mask. The mask is 0x001 for revision 1, 0x01F for revision 1 with the extension, 0x21F for revision 2 and 0x61F for revision 2 with the extension. Bit 0 enables group 0, bit 1 enables group 1, bit 2 controls acknowledge, bit 3 enables the fast interrupt, bit 4 selects the common binary point, bit 9 is the end-of-interrupt mode and bit 10 is the non-secure end-of-interrupt mode.
- R3: With the extension present, a non-secure read of offset 0x000 returns stored bit 1 at bit 0 and stored bit 10 at bit 9. Every other bit reads zero.
- R4: With the extension present, a non-secure write to offset 0x000 copies write-data bit 0 into stored bit 1. In revision 2 it also copies write-data bit 9 into stored bit 10. No other stored bit changes.
- R5: Offset 0x004 holds an 8-bit priority mask per processor. Writes keep the low 8 bits, and reads return the mask zero-extended. This register is the same for secure and non-secure accesses.
- R6: Any other offset reads as zero, and a write to it changes no state.
- R7: `rd_data` is registered. It shows the value selected by the address, index and attribute present on the previous rising edge.
- R8: `irq_out[i]` is low and pending slice i reads 1023 when both distributor enables are low, or when bits 1:0 of processor i's control word are both zero. Otherwise the slice and line pass `pend_in` and `irq_in` through.
- R9: Each processor's registers are independent. An index of NPROC or above reads zero and its writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_cpu | input | IW | Processor index of the access |
| acc_secure | input | 1 | Access is secure |
| acc_addr | input | AW | Byte offset in the CPU-interface space |
| acc_we | input | 1 | Write strobe |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| dist_en_g0 | input | 1 | Distributor group 0 enable |
| dist_en_g1 | input | 1 | Distributor group 1 enable |
| irq_in | input | NPROC | Interrupt request per processor from the controller |
| pend_in | input | NPROC*IDW | Pending ID per processor from the controller |
| irq_out | output | NPROC | Gated interrupt line per processor |
| pend_out | output | NPROC*IDW | Gated pending ID per processor |

## Verification
A corrupted control word becomes visible at the ports in two ways. It shows in `rd_data` on the clock after a read of that processor. It shows at once on that processor's `irq_out` and pending slice whenever the group-enable bits are wrong. A wrong non-secure mask shows up as a changed secure-only bit on the next secure read. A wrong alias shifts bits into the wrong positions on the very next non-secure read. All four revision and extension configurations run the same vector table side by side, so a mask error in any one of them appears in the first read-back after the offending write.

// File: rtl/cpuif_ctrl_bank.sv
module cpuif_ctrl_bank #(
  parameter int NPROC  = 3,
  parameter int REV    = 2,
  parameter int SECEXT = 1,
  parameter int AW     = 12,
  parameter int IDW    = 10,
  localparam int IW    = NPROC > 1 ? $clog2(NPROC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IW-1:0]        acc_cpu,
  input  logic                 acc_secure,
  input  logic [AW-1:0]        acc_addr,
  input  logic                 acc_we,
  input  logic [31:0]          acc_wdata,
  output logic [31:0]          rd_data,
  input  logic                 dist_en_g0,
  input  logic                 dist_en_g1,
  input  logic [NPROC-1:0]     irq_in,
  input  logic [NPROC*IDW-1:0] pend_in,
  output logic [NPROC-1:0]     irq_out,
  output logic [NPROC*IDW-1:0] pend_out
);
  localparam logic [31:0] WMASK  = (REV == 2) ? (SECEXT != 0 ? 32'h61F : 32'h21F)
                                              : (SECEXT != 0 ? 32'h01F : 32'h001);
  localparam logic [31:0] NSMASK = (REV == 2) ? 32'h402 : 32'h002;
  localparam logic [31:0] ALIAS  = 32'h402;
  localparam logic [AW-1:0] OFS_CTL = AW'(0);
  localparam logic [AW-1:0] OFS_PMR = AW'(4);
  localparam logic [IDW-1:0] SPURIOUS = IDW'(1023);

  logic [NPROC-1:0][31:0] ctl_q;
  logic [NPROC-1:0][7:0]  pmr_q;
  logic [31:0] ctl_cur, ctl_view, ctl_next, rd_next;
  logic [7:0]  pmr_cur;

  wire cpu_ok  = int'(acc_cpu) < NPROC;
  wire ns_view = (SECEXT != 0) && !acc_secure;
  wire sel_ctl = cpu_ok && (acc_addr == OFS_CTL);
  wire sel_pmr = cpu_ok && (acc_addr == OFS_PMR);

  always_comb begin
    ctl_cur = '0;
    pmr_cur = '0;
    if (cpu_ok) begin
      ctl_cur = ctl_q[acc_cpu];
      pmr_cur = pmr_q[acc_cpu];
    end
  end

  assign ctl_view = ns_view ? ((ctl_cur & ALIAS) >> 1) : ctl_cur;
  assign ctl_next = ns_view ? ((ctl_cur & ~NSMASK) | ((acc_wdata << 1) & NSMASK))
                            : (acc_wdata & WMASK);
  assign rd_next  = sel_ctl ? ctl_view : (sel_pmr ? {24'b0, pmr_cur} : 32'b0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;

  wire dist_on = dist_en_g0 | dist_en_g1;

  for (genvar g = 0; g < NPROC; g++) begin : g_proc
    wire hit = acc_we && (acc_cpu == IW'(g));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ctl_q[g] <= '0;
        pmr_q[g] <= '0;
      end else begin
        if (hit && sel_ctl) ctl_q[g] <= ctl_next;
        if (hit && sel_pmr) pmr_q[g] <= acc_wdata[7:0];
      end

    wire fwd = dist_on && (ctl_q[g][0] | ctl_q[g][1]);
    assign irq_out[g] = irq_in[g] & fwd;
    assign pend_out[g*IDW +: IDW] = fwd ? pend_in[g*IDW +: IDW] : SPURIOUS;
  end
endmodule

// File: rtl/cpuif_ctrl_bank_chk.sv
module cpuif_ctrl_bank_chk #(
  parameter int NPROC  = 3,
  parameter int REV    = 2,
  parameter int SECEXT = 1,
  parameter int AW     = 12,
  parameter int IDW    = 10,
  parameter int IW     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [IW-1:0]        acc_cpu,
  input logic                 acc_secure,
  input logic [AW-1:0]        acc_addr,
  input logic                 acc_we,
  input logic [31:0]          rd_data,
  input logic                 dist_en_g0,
  input logic                 dist_en_g1,
  input logic [NPROC-1:0]     irq_out,
  input logic [NPROC*IDW-1:0] pend_out,
  input logic [NPROC-1:0][31:0] ctl_q
);
  localparam logic [31:0] LEGAL = (REV == 2) ? (SECEXT != 0 ? 32'h61F : 32'h21F)
                                             : (SECEXT != 0 ? 32'h01F : 32'h001);

  p_dist_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dist_en_g0 && !dist_en_g1) |-> (irq_out == '0));

  p_undef_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && acc_addr != AW'(0) && acc_addr != AW'(4)) |=> $stable(ctl_q));

  for (genvar i = 0; i < NPROC; i++) begin : g_chk
    p_cpu_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[i][1:0] == 2'b00) |->
        (!irq_out[i] && pend_out[i*IDW +: IDW] == IDW'(1023)));

    p_legal_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[i] & ~LEGAL) == 32'h0);

    if (SECEXT != 0) begin : g_sec
      p_ns_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && !acc_secure && acc_addr == AW'(0) && acc_cpu == IW'(i)) |=>
          ((ctl_q[i] & ~32'h402) == ($past(ctl_q[i]) & ~32'h402)));
    end
  end

  if (SECEXT != 0) begin : g_nsrd
    p_ns_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_secure && acc_addr == AW'(0)) |=> ((rd_data & ~32'h201) == 32'h0));
  end
endmodule

bind cpuif_ctrl_bank cpuif_ctrl_bank_chk #(
  .NPROC(NPROC), .REV(REV), .SECEXT(SECEXT), .AW(AW), .IDW(IDW), .IW(IW)
) u_chk (.*);

// File: tb/test_cpuif_ctrl_bank.sv
module test_cpuif_ctrl_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NPROC = 3;
  localparam int AW = 12;
  localparam int IDW = 10;
  localparam int IW = 2;

  typedef struct packed {
    logic        we;
    logic        sec;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] e0, e1, e2, e3;
  } vec_t;

  // configs: e0 rev1 no-ext, e1 rev1 ext, e2 rev2 no-ext, e3 rev2 ext; processor 1
  localparam int NV = 9;
  localparam logic [173:0] VEC [NV] = '{
    {1'b1, 1'b1, 12'h000, 32'hFFFFFFFF, 32'h001, 32'h01F, 32'h21F, 32'h61F},
    {1'b1, 1'b0, 12'h000, 32'h00000000, 32'h000, 32'h000, 32'h000, 32'h000},
    {1'b1, 1'b0, 12'h000, 32'h00000201, 32'h001, 32'h001, 32'h201, 32'h201},
    {1'b1, 1'b1, 12'h000, 32'h00000402, 32'h000, 32'h002, 32'h002, 32'h402},
    {1'b0, 1'b0, 12'h000, 32'h00000000, 32'h000, 32'h001, 32'h002, 32'h201},
    {1'b1, 1'b1, 12'h004, 32'h12345678, 32'h078, 32'h078, 32'h078, 32'h078},
    {1'b1, 1'b1, 12'h008, 32'hFFFFFFFF, 32'h000, 32'h000, 32'h000, 32'h000},
    {1'b0, 1'b1, 12'h000, 32'h00000000, 32'h000, 32'h002, 32'h002, 32'h402},
    {1'b0, 1'b0, 12'h004, 32'h00000000, 32'h078, 32'h078, 32'h078, 32'h078}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] acc_cpu = '0;
  logic acc_secure = 1'b1;
  logic [AW-1:0] acc_addr = '0;
  logic acc_we = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic dist_en_g0 = 1'b1;
  logic dist_en_g1 = 1'b0;
  logic [NPROC-1:0] irq_in = '1;
  logic [NPROC*IDW-1:0] pend_in = {10'd7, 10'd6, 10'd5};
  logic [31:0] rd0, rd1, rd2, rd3;
  logic [NPROC-1:0] irq0, irq1, irq2, irq3;
  logic [NPROC*IDW-1:0] pd0, pd1, pd2, pd3;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpuif_ctrl_bank #(.NPROC(NPROC), .REV(1), .SECEXT(0)) i_cpuif_ctrl_bank_r1 (
    .clk, .rst_n, .acc_cpu, .acc_secure, .acc_addr, .acc_we, .acc_wdata, .rd_data(rd0),
    .dist_en_g0, .dist_en_g1, .irq_in, .pend_in, .irq_out(irq0), .pend_out(pd0));
  cpuif_ctrl_bank #(.NPROC(NPROC), .REV(1), .SECEXT(1)) i_cpuif_ctrl_bank_r1s (
    .clk, .rst_n, .acc_cpu, .acc_secure, .acc_addr, .acc_we, .acc_wdata, .rd_data(rd1),
    .dist_en_g0, .dist_en_g1, .irq_in, .pend_in, .irq_out(irq1), .pend_out(pd1));
  cpuif_ctrl_bank #(.NPROC(NPROC), .REV(2), .SECEXT(0)) i_cpuif_ctrl_bank_r2 (
    .clk, .rst_n, .acc_cpu, .acc_secure, .acc_addr, .acc_we, .acc_wdata, .rd_data(rd2),
    .dist_en_g0, .dist_en_g1, .irq_in, .pend_in, .irq_out(irq2), .pend_out(pd2));
  cpuif_ctrl_bank #(.NPROC(NPROC)) i_cpuif_ctrl_bank (
    .clk, .rst_n, .acc_cpu, .acc_secure, .acc_addr, .acc_we, .acc_wdata, .rd_data(rd3),
    .dist_en_g0, .dist_en_g1, .irq_in, .pend_in, .irq_out(irq3), .pend_out(pd3));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int cpu, input logic sec, input logic [AW-1:0] a, input logic [31:0] d);
    acc_cpu = IW'(cpu); acc_secure = sec; acc_addr = a; acc_wdata = d; acc_we = 1'b1;
    @(negedge clk);
    acc_we = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic sec, input logic [AW-1:0] a);
    acc_cpu = IW'(cpu); acc_secure = sec; acc_addr = a; acc_we = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rd_data", rd3, 32'h0);
    chk("R1 irq_out", 32'(irq3), 32'h0);
    chk("R1 pend cpu0", 32'(pd3[0 +: IDW]), 32'd1023);
    rd(0, 1'b1, 12'h000);
    chk("R1 ctl cpu0", rd3, 32'h0);
    rd(2, 1'b1, 12'h004);
    chk("R1 pmr cpu2", rd3, 32'h0);

    // R2 R3 R4 R5 R6 table over all four configurations
    for (int i = 0; i < NV; i++) begin
      v = vec_t'(VEC[i]);
      if (v.we) wr(1, v.sec, v.addr, v.wdata);
      rd(1, v.sec, v.addr);
      chk($sformatf("R2/R3/R4/R5/R6 vec%0d rev1", i), rd0, v.e0);
      chk($sformatf("R2/R3/R4/R5/R6 vec%0d rev1ext", i), rd1, v.e1);
      chk($sformatf("R2/R3/R4/R5/R6 vec%0d rev2", i), rd2, v.e2);
      chk($sformatf("R2/R3/R4/R5/R6 vec%0d rev2ext", i), rd3, v.e3);
    end

    // R9 processor 0 untouched by the table
    rd(0, 1'b1, 12'h000);
    chk("R9 cpu0 ctl", rd3, 32'h0);

    // R8 gating: cpu1 has group 1 enabled, cpu0 nothing
    chk("R8 irq cpu1 pass", 32'(irq3[1]), 32'h1);
    chk("R8 pend cpu1 pass", 32'(pd3[IDW +: IDW]), 32'd6);
    chk("R8 irq cpu0 gated", 32'(irq3[0]), 32'h0);
    chk("R8 pend cpu0 gated", 32'(pd3[0 +: IDW]), 32'd1023);
    chk("R8 rev1 cpu1 gated", 32'(irq0[1]), 32'h0);
    dist_en_g0 = 1'b0;
    #1;
    chk("R8 dist off irq", 32'(irq3[1]), 32'h0);
    chk("R8 dist off pend", 32'(pd3[IDW +: IDW]), 32'd1023);
    dist_en_g1 = 1'b1;
    #1;
    chk("R8 dist g1 irq", 32'(irq3[1]), 32'h1);
    @(negedge clk);

    // R9 out-of-range index
    wr(3, 1'b1, 12'h000, 32'hFFFFFFFF);
    rd(3, 1'b1, 12'h000);
    chk("R9 idx3 reads zero", rd3, 32'h0);
    rd(2, 1'b1, 12'h000);
    chk("R9 cpu2 unchanged", rd3, 32'h0);

    // R4 R3 non-secure enable on cpu2
    wr(2, 1'b0, 12'h000, 32'h00000001);
    chk("R4 ns enable irq cpu2", 32'(irq3[2]), 32'h1);
    rd(2, 1'b0, 12'h000);
    chk("R3 ns view cpu2", rd3, 32'h1);
    rd(2, 1'b1, 12'h000);
    chk("R4 secure view cpu2", rd3, 32'h2);

    // R7 read data lags the address by one edge
    acc_cpu = IW'(1); acc_secure = 1'b1; acc_addr = 12'h000;
    #1;
    chk("R7 before edge", rd3, 32'h2);
    @(negedge clk);
    chk("R7 after edge", rd3, 32'h402);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule